// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting timer channel. A CPU programs it through a byte-wide write port. A control word selects one of six counting behaviours and the order in which count bytes arrive. The channel then drives a single output pin from its counting clock and its gate input. The count bytes land in a holding register. The counting element picks up the holding value on a later counting clock, so writing a new count never corrupts a count that is already running.

The CPU clock and the counting clock are one synchronous clock. The counting clock is the `tick` enable pulse, and every counting action happens on a rising `clk` edge where `tick` is high. The six behaviours are:
- one-time interrupt at terminal count
- retriggerable one-shot
- rate divider
- square wave
- software-started strobe
- gate-started strobe

Two gate rules apply. A gate rising edge seen on any clock is remembered until the next tick. A low gate in the divider modes forces the output high on the next clock, with no tick needed.

Top module: `ivt_channel`

## Requirements
- R1: After reset the output is high, and ticks have no effect until the channel is programmed.
- R2: A write with `wr_ctrl`=1 is a control word. Bits [2:0] hold the mode: 0 terminal interrupt, 1 one-shot, 2 rate, 3 square, 4 soft strobe, 5 gate strobe. Codes 6 and 7 act as 2 and 3. Bits [4:3] hold the byte format: 01 low byte only, 10 high byte only, 11 or 00 low byte then high byte. Bits [7:5] are ignored. A control word clears the holding register and stops counting. It sets the output low in mode 0 and high in every other mode.
- R3: In the one-byte formats the unwritten byte of the count is zero, so a high-byte-only write of 1 gives a count of 256. The count moves to the counter on the first tick after the write, never at the write itself.
- R4: In the two-byte format the first count write fills the low byte and the second fills the high byte. In modes 0 and 4, the first byte halts any counting in progress, and counting starts again only after the second byte.
- R5: Mode 0: every count byte write drives the output low. The tick after the count is complete loads the counter. The output rises on the N-th following tick that has gate high, and it stays high until the next control word or count write. Ticks with gate low do not count.
- R6: Mode 1: a gate rising edge arms a trigger. The next tick loads the count and drives the output low for exactly N ticks. A new trigger during the pulse restarts the full N. Triggers before any count has been written do nothing.
- R7: Mode 2: with the load tick numbered 0, the output is low only on ticks N-1, 2N-1, 3N-1 and so on, for one tick each. Gate low forces the output high on the next clock and pauses counting. A gate rising edge reloads the count on the next tick.
- R8: Mode 3: the output is high for ceil(N/2) ticks and then low for floor(N/2) ticks, repeating. Gate low forces the output high on the next clock, and a gate rising edge restarts the wave from its high phase.
- R9: Mode 4: the output is high after programming. With the load tick numbered 0, it is low only on tick N, and no further strobe follows.
- R10: Mode 5: nothing happens until a gate rising edge. The next tick loads the count without decrementing it. The output is low only on the N-th tick after that load tick. Each new trigger restarts the strobe count.
- R11: A count value of 0 acts as 65536.
- R12: The output changes only on a tick, on a CPU write, or through the gate-low force in modes 2 and 3; in all other clocks it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the CPU side and the counter |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counting clock enable, one pulse per count step |
| gate | input | 1 | Gate: count enable level and trigger edge |
| wr_en | input | 1 | CPU write strobe, one clock per byte |
| wr_ctrl | input | 1 | 1: control word, 0: count byte |
| wr_data | input | 8 | Write data byte |
| out | output | 1 | Channel output |

## Verification
Each mode is driven with a small count and its output is compared tick by tick with the pattern from the requirements. Odd and even square-wave counts separate the ceiling and floor split. The count-byte patterns are a single low byte, a single high byte of 1, a low-then-high pair, a pair interrupted mid-way, and a zero count. Together they show whether the unwritten byte is really cleared, whether the byte toggle is honoured, and whether zero wraps to 65536 rather than stopping. Gate patterns are applied with each mode's own rule, so a design that mixes up the modes fails:
- gate edges before and during a pulse, which test retrigger and ignore-before-programming;
- gate low while the output is low, which tests the forced high;
- gate low mid-count in mode 0, which tests pausing.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } ivt_mode_e;

    typedef enum logic [1:0] {
        F_LOW  = 2'd1,
        F_HIGH = 2'd2,
        F_PAIR = 2'd3
    } ivt_fmt_e;

    typedef struct packed {
        ivt_fmt_e  fmt;
        ivt_mode_e mode;
    } ivt_ctrl_t;

    function automatic ivt_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd0:    return M_TERM;
            3'd1:    return M_ONESHOT;
            3'd2:    return M_RATE;
            3'd3:    return M_SQUARE;
            3'd4:    return M_SWSTROBE;
            3'd5:    return M_HWSTROBE;
            3'd6:    return M_RATE;
            default: return M_SQUARE;
        endcase
    endfunction

    function automatic ivt_fmt_e decode_fmt(input logic [1:0] code);
        case (code)
            2'd1:    return F_LOW;
            2'd2:    return F_HIGH;
            default: return F_PAIR;
        endcase
    endfunction

    function automatic ivt_ctrl_t decode_ctrl(input logic [4:0] word);
        ivt_ctrl_t c;
        c.mode = decode_mode(word[2:0]);
        c.fmt  = decode_fmt(word[4:3]);
        return c;
    endfunction

    function automatic logic loads_on_write(input ivt_mode_e m);
        return (m == M_TERM) || (m == M_SWSTROBE);
    endfunction

    function automatic logic is_divider(input ivt_mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

endpackage

// File: rtl/ivt_host_regs.sv
module ivt_host_regs
    import ivt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ctrl_wr_o,
    output ivt_mode_e         ctrl_mode_o,
    output logic              byte_wr_o,
    output logic              cnt_done_o,
    output ivt_mode_e         mode_o,
    output logic [CNT_W-1:0]  hold_o
);
    localparam int LANES = CNT_W / DATA_W;

    ivt_ctrl_t        cw;
    ivt_mode_e        mode_q;
    ivt_fmt_e         fmt_q;
    logic             toggle_q;
    logic [LANES-1:0] lane_sel;
    logic [CNT_W-1:0] hold_q;
    logic             unused_hi_bits;

    assign cw             = decode_ctrl(wr_data[4:0]);
    assign unused_hi_bits = ^wr_data[DATA_W-1:5];
    assign ctrl_wr_o      = wr_en & wr_ctrl;
    assign byte_wr_o      = wr_en & ~wr_ctrl;
    assign ctrl_mode_o    = cw.mode;
    assign cnt_done_o     = byte_wr_o & ((fmt_q != F_PAIR) | toggle_q);
    assign mode_o         = mode_q;
    assign hold_o         = hold_q;

    assign lane_sel[0] = (fmt_q == F_LOW)  | ((fmt_q == F_PAIR) & ~toggle_q);
    assign lane_sel[1] = (fmt_q == F_HIGH) | ((fmt_q == F_PAIR) &  toggle_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= M_TERM;
            fmt_q    <= F_PAIR;
            toggle_q <= 1'b0;
        end else if (ctrl_wr_o) begin
            mode_q   <= cw.mode;
            fmt_q    <= cw.fmt;
            toggle_q <= 1'b0;
        end else if (byte_wr_o && fmt_q == F_PAIR) begin
            toggle_q <= ~toggle_q;
        end
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || ctrl_wr_o) begin
                hold_q[b*DATA_W +: DATA_W] <= '0;
            end else if (byte_wr_o && lane_sel[b]) begin
                hold_q[b*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/ivt_gate_edge.sv
module ivt_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    output logic rise_o
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate;
    end

    assign rise_o = gate & ~gate_q;
endmodule

// File: rtl/ivt_count_core.sv
module ivt_count_core
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate,
    input  logic             gate_rise,
    input  logic             ctrl_wr,
    input  ivt_mode_e        ctrl_mode,
    input  logic             byte_wr,
    input  logic             cnt_done,
    input  ivt_mode_e        mode,
    input  logic [CNT_W-1:0] hold,
    output logic             out_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] cnt_q;
    logic             out_q, running_q, load_pend_q, trig_pend_q, have_cnt_q;
    logic             trig_now;
    logic [CNT_W:0]   hold_ext, hold_inc;
    logic [CNT_W-1:0] half_hi, half_lo;

    assign trig_now = trig_pend_q | gate_rise;
    assign hold_ext = (hold == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, hold};
    assign hold_inc = hold_ext + {{CNT_W{1'b0}}, 1'b1};
    assign half_hi  = hold_inc[CNT_W:1];
    assign half_lo  = hold_ext[CNT_W:1];
    assign out_o    = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            out_q       <= 1'b1;
            running_q   <= 1'b0;
            load_pend_q <= 1'b0;
            trig_pend_q <= 1'b0;
            have_cnt_q  <= 1'b0;
        end else if (ctrl_wr) begin
            out_q       <= (ctrl_mode != M_TERM);
            running_q   <= 1'b0;
            load_pend_q <= 1'b0;
            trig_pend_q <= 1'b0;
            have_cnt_q  <= 1'b0;
        end else if (byte_wr) begin
            trig_pend_q <= trig_now;
            if (mode == M_TERM) out_q <= 1'b0;
            if (loads_on_write(mode) && !cnt_done) running_q <= 1'b0;
            if (cnt_done) begin
                have_cnt_q <= 1'b1;
                if (loads_on_write(mode) || (is_divider(mode) && !running_q))
                    load_pend_q <= 1'b1;
            end
        end else begin
            trig_pend_q <= trig_now;
            if (is_divider(mode) && !gate) out_q <= 1'b1;
            if (tick) begin
                trig_pend_q <= 1'b0;
                case (mode)
                    M_TERM: begin
                        if (load_pend_q) begin
                            cnt_q <= hold; load_pend_q <= 1'b0; running_q <= 1'b1;
                        end else if (running_q && gate) begin
                            cnt_q <= cnt_q - ONE;
                            if (cnt_q == ONE) out_q <= 1'b1;
                        end
                    end
                    M_SWSTROBE: begin
                        if (load_pend_q) begin
                            cnt_q <= hold; load_pend_q <= 1'b0;
                            running_q <= 1'b1; out_q <= 1'b1;
                        end else if (running_q && !out_q) begin
                            out_q <= 1'b1; running_q <= 1'b0;
                        end else if (running_q && gate) begin
                            cnt_q <= cnt_q - ONE;
                            if (cnt_q == ONE) out_q <= 1'b0;
                        end
                    end
                    M_ONESHOT: begin
                        if (trig_now && have_cnt_q) begin
                            cnt_q <= hold; out_q <= 1'b0; running_q <= 1'b1;
                        end else if (running_q) begin
                            cnt_q <= cnt_q - ONE;
                            if (cnt_q == ONE) begin
                                out_q <= 1'b1; running_q <= 1'b0;
                            end
                        end
                    end
                    M_HWSTROBE: begin
                        if (trig_now && have_cnt_q) begin
                            cnt_q <= hold; out_q <= 1'b1; running_q <= 1'b1;
                        end else if (running_q && !out_q) begin
                            out_q <= 1'b1; running_q <= 1'b0;
                        end else if (running_q) begin
                            cnt_q <= cnt_q - ONE;
                            if (cnt_q == ONE) out_q <= 1'b0;
                        end
                    end
                    M_RATE: begin
                        if (load_pend_q || (trig_now && have_cnt_q)) begin
                            cnt_q <= hold; out_q <= 1'b1;
                            running_q <= 1'b1; load_pend_q <= 1'b0;
                        end else if (running_q && gate) begin
                            if (cnt_q == ONE) begin
                                cnt_q <= hold; out_q <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q - ONE;
                                if (cnt_q == TWO) out_q <= 1'b0;
                            end
                        end
                    end
                    M_SQUARE: begin
                        if (load_pend_q || (trig_now && have_cnt_q)) begin
                            cnt_q <= half_hi; out_q <= 1'b1;
                            running_q <= 1'b1; load_pend_q <= 1'b0;
                        end else if (running_q && gate) begin
                            if (cnt_q == ONE) begin
                                out_q <= ~out_q;
                                cnt_q <= out_q ? half_lo : half_hi;
                            end else begin
                                cnt_q <= cnt_q - ONE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              gate,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    output logic              out
);
    localparam int CNT_W = 2 * DATA_W;

    logic             ctrl_wr_w, byte_wr_w, cnt_done_w, gate_rise_w;
    ivt_mode_e        ctrl_mode_w, mode_w;
    logic [CNT_W-1:0] hold_w;

    ivt_host_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_host (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_ctrl    (wr_ctrl),
        .wr_data    (wr_data),
        .ctrl_wr_o  (ctrl_wr_w),
        .ctrl_mode_o(ctrl_mode_w),
        .byte_wr_o  (byte_wr_w),
        .cnt_done_o (cnt_done_w),
        .mode_o     (mode_w),
        .hold_o     (hold_w)
    );

    ivt_gate_edge u_gate (
        .clk   (clk),
        .rst   (rst),
        .gate  (gate),
        .rise_o(gate_rise_w)
    );

    ivt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .gate     (gate),
        .gate_rise(gate_rise_w),
        .ctrl_wr  (ctrl_wr_w),
        .ctrl_mode(ctrl_mode_w),
        .byte_wr  (byte_wr_w),
        .cnt_done (cnt_done_w),
        .mode     (mode_w),
        .hold     (hold_w),
        .out_o    (out)
    );
endmodule

// File: rtl/ivt_channel_chk.sv
module ivt_channel_chk
    import ivt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       gate,
    input logic       wr_en,
    input logic       wr_ctrl,
    input logic [2:0] cw_mode_bits,
    input logic       out,
    input ivt_mode_e  mode
);
    // R2: a control word selecting mode 0 drives the output low
    a_r2_term_ctrl_low: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl && cw_mode_bits == 3'd0) |=> !out);

    // R5: once high in mode 0 the output stays high until a write
    a_r5_term_stays_high: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && out && mode == M_TERM) |=> out);

    // R7, R8: gate low in the divider modes forces the output high
    a_r7_gate_forces_high: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !gate && (mode == M_RATE || mode == M_SQUARE)) |=> out);

    // R9: low phases of rate and strobe modes last one tick
    a_r9_single_tick_low: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && !out &&
         (mode == M_RATE || mode == M_SWSTROBE || mode == M_HWSTROBE)) |=> out);

    // R12: no tick, no write and gate high leave the output unchanged
    a_r12_out_holds: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en && gate) |=> $stable(out));
endmodule

bind ivt_channel ivt_channel_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .gate        (gate),
    .wr_en       (wr_en),
    .wr_ctrl     (wr_ctrl),
    .cw_mode_bits(wr_data[2:0]),
    .out         (out),
    .mode        (mode_w)
);

// File: tb/ivt_channel_tb.sv
module ivt_channel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       gate = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       out;
    logic       tick_d = 1'b0;
    logic       done = 1'b0;

    logic  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail = 0;

    ivt_channel dut_i (
        .clk(clk), .rst(rst), .tick(tick), .gate(gate),
        .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data), .out(out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) tick_d <= tick;

    // Monitor: one expected output value per tick, compared a half clock later
    always @(negedge clk) begin
        if (tick_d && !done) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard: tick with no expected value, actual %0b expected none", out);
            end else begin
                automatic logic  e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                n_checks++;
                if (out !== e) begin
                    n_fail++;
                    $display("FAIL %s: out=%0b expected %0b", t, out, e);
                end
            end
        end
    end

    task automatic chk(input logic e, input string t);
        n_checks++;
        if (out !== e) begin
            n_fail++;
            $display("FAIL %s: out=%0b expected %0b", t, out, e);
        end
    endtask

    task automatic wr(input logic c, input logic [7:0] d);
        wr_en = 1'b1; wr_ctrl = c; wr_data = d; tick = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tk(input logic e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic tk_n(input int n, input logic e, input string t);
        for (int i = 0; i < n; i++) tk(e, t);
    endtask

    task automatic set_gate(input logic v);
        gate = v;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run still active, actual %0d cycles expected fewer", WATCHDOG);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(1'b1, "R1 reset output");
        tk_n(3, 1'b1, "R1 ticks before programming");

        // Mode 0, low byte only (ctrl bits[4:3]=01), count 5, gate high
        set_gate(1'b1);
        wr(1'b1, 8'h08);
        chk(1'b0, "R2 mode 0 control word drives low");
        wr(1'b0, 8'd5);
        chk(1'b0, "R5 low after count write");
        tk_n(5, 1'b0, "R5 counting N=5");
        tk_n(3, 1'b1, "R5 high after terminal count");
        wr(1'b0, 8'd2);
        chk(1'b0, "R5 new count write drives low");
        tk_n(2, 1'b0, "R5 counting N=2");
        tk(1'b1, "R5 terminal N=2");
        // gate pause
        wr(1'b0, 8'd3);
        tk_n(2, 1'b0, "R5 before pause");
        set_gate(1'b0);
        tk_n(4, 1'b0, "R5 gate low pauses");
        set_gate(1'b1);
        tk(1'b0, "R5 resume");
        tk(1'b1, "R5 terminal after pause");

        // High byte only (bits[4:3]=10): 1 -> 256
        wr(1'b1, 8'h10);
        wr(1'b0, 8'd1);
        tk_n(256, 1'b0, "R3 high-only count 256 low");
        tk_n(2, 1'b1, "R3 high-only count 256 done");

        // Low then high (bits[4:3]=11)
        wr(1'b1, 8'h18);
        wr(1'b0, 8'd4);
        tk_n(3, 1'b0, "R4 waits for second byte");
        wr(1'b0, 8'd0);
        tk_n(4, 1'b0, "R4 pair count 4");
        tk_n(2, 1'b1, "R4 pair count 4 done");
        wr(1'b0, 8'd6);
        chk(1'b0, "R4 first byte drives low");
        tk_n(3, 1'b0, "R4 halted after first byte");
        wr(1'b0, 8'd0);
        tk_n(6, 1'b0, "R4 pair count 6");
        tk(1'b1, "R4 pair count 6 done");

        // Zero count in mode 0
        wr(1'b1, 8'h08);
        wr(1'b0, 8'd0);
        tk_n(65536, 1'b0, "R11 zero count low");
        tk_n(2, 1'b1, "R11 zero count done");

        // Mode 1 one-shot, count 4
        wr(1'b1, 8'h09);
        chk(1'b1, "R2 nonzero mode control word drives high");
        set_gate(1'b0);
        set_gate(1'b1);
        tk_n(2, 1'b1, "R6 trigger before count ignored");
        set_gate(1'b0);
        wr(1'b0, 8'd4);
        tk_n(2, 1'b1, "R6 no trigger yet");
        set_gate(1'b1);
        tk_n(4, 1'b0, "R6 pulse N=4");
        tk_n(2, 1'b1, "R6 pulse end");
        set_gate(1'b0);
        set_gate(1'b1);
        tk_n(2, 1'b0, "R6 first part of pulse");
        set_gate(1'b0);
        set_gate(1'b1);
        tk_n(4, 1'b0, "R6 retrigger restarts pulse");
        tk_n(2, 1'b1, "R6 retriggered pulse end");

        // Mode 2 rate, count 4
        wr(1'b1, 8'h0A);
        wr(1'b0, 8'd4);
        tk_n(3, 1'b1, "R7 high phase");
        tk(1'b0, "R7 low tick");
        tk_n(3, 1'b1, "R7 second period");
        tk(1'b0, "R7 second low tick");
        set_gate(1'b0);
        chk(1'b1, "R7 gate low forces high");
        tk_n(2, 1'b1, "R7 paused");
        set_gate(1'b1);
        tk_n(3, 1'b1, "R7 reload after gate rise");
        tk(1'b0, "R7 low after reload");
        tk(1'b1, "R7 high after reload pulse");

        // Mode 3 square, count 5
        wr(1'b1, 8'h0B);
        wr(1'b0, 8'd5);
        tk_n(3, 1'b1, "R8 odd high phase");
        tk_n(2, 1'b0, "R8 odd low phase");
        tk_n(3, 1'b1, "R8 odd high again");
        tk_n(2, 1'b0, "R8 odd low again");
        set_gate(1'b0);
        chk(1'b1, "R8 gate low forces high");
        set_gate(1'b1);
        tk_n(3, 1'b1, "R8 restart high");
        tk_n(2, 1'b0, "R8 restart low");

        // Code 7 with bits[7:5] set acts as square, low byte only, count 4
        wr(1'b1, 8'hEF);
        wr(1'b0, 8'd4);
        tk_n(2, 1'b1, "R2 code 7 as square high");
        tk_n(2, 1'b0, "R2 code 7 as square low");
        tk_n(2, 1'b1, "R2 code 7 as square high again");

        // Mode 4 soft strobe
        wr(1'b1, 8'h0C);
        chk(1'b1, "R9 high after programming");
        wr(1'b0, 8'd3);
        tk_n(3, 1'b1, "R9 count N=3");
        tk(1'b0, "R9 strobe");
        tk_n(3, 1'b1, "R9 single strobe only");
        wr(1'b0, 8'd5);
        tk_n(5, 1'b1, "R9 count N=5");
        tk(1'b0, "R9 strobe N=5");
        idle(3);
        chk(1'b0, "R12 output holds without tick");
        tk_n(2, 1'b1, "R9 after strobe N=5");

        // Mode 5 gate strobe
        wr(1'b1, 8'h0D);
        wr(1'b0, 8'd3);
        set_gate(1'b0);
        tk_n(3, 1'b1, "R10 no trigger");
        set_gate(1'b1);
        tk_n(3, 1'b1, "R10 load and count");
        tk(1'b0, "R10 strobe");
        tk_n(2, 1'b1, "R10 after strobe");
        set_gate(1'b0);
        set_gate(1'b1);
        tk_n(2, 1'b1, "R10 partial count");
        set_gate(1'b0);
        set_gate(1'b1);
        tk_n(3, 1'b1, "R10 retrigger restarts");
        tk(1'b0, "R10 strobe after retrigger");
        tk(1'b1, "R10 after retrigger strobe");

        idle(2);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: %0d expected values left, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule